// File: doc/BRIEF.md
# LIN Remote Wake-Up Filter

This block watches the digitized receive level of a LIN bus while the node sits in a low-power state. It reports a remote wake-up only when it sees the full pattern. First the bus must go from recessive to dominant. The bus must then stay dominant for longer than a programmable number of clock cycles. Finally the bus must return to recessive. The wake request is a single-cycle pulse, issued on that closing recessive edge.

A mode controller outside this block drives the arm input. It holds arm high while the node is in sleep or silent mode. It also drives a silent-mode select, which says which of the two modes is active. In silent mode a wake-up is accepted only while the transmit-data level is high. In sleep mode the transmit-data level is ignored. Whenever the detector is not enabled, all of its state returns to idle in one cycle.

The bus input passes through a two-flop synchronizer before edge detection. The filter length `FILTER_CYCLES` is the nominal 100 µs filter time expressed in clock cycles. Any value that lands between 50 and 150 µs is acceptable. The default of 2000 assumes a 20 MHz clock.

Top module: `linWakeFilter`

## Requirements
- R1: A dominant run that lasts more than `FILTER_CYCLES` clock cycles, measured at `busDom`, produces `wakePulse` when the bus returns to recessive. The pulse appears on the third rising clock edge after the first edge that samples `busDom` low.
- R2: `wakePulse` is high for exactly one clock cycle for each qualifying dominant run.
- R3: A dominant run of `FILTER_CYCLES` cycles or fewer produces no wake. The recessive edge that ends such a run is ignored, and the detector returns to idle.
- R4: A dominant level that never ends produces no wake. The detector waits until the recessive edge comes, and a wake is issued on that edge.
- R5: When `silentSel` is 1, a wake is accepted only while `txdLevel` is 1. With `txdLevel` at 0, no wake is issued.
- R6: When `silentSel` is 0, `txdLevel` has no effect on detection.
- R7: With `arm` low, the detector is cleared to idle in one cycle and `wakePulse` stays low. A dominant run that was in progress at that time cannot produce a wake on its later recessive edge while the detector remains disarmed.
- R8: While `rstN` is low, and after it is released, `wakePulse` is 0 until a qualifying pattern is seen.
- R9: `busDom` is sampled through two synchronizing flops before edges are detected. This is what sets the three-edge latency given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | High while the node is in sleep or silent mode |
| silentSel | input | 1 | 1 = silent mode (transmit-data gating applies), 0 = sleep mode |
| txdLevel | input | 1 | Transmit-data pin level |
| busDom | input | 1 | Receiver output, 1 = bus dominant, asynchronous |
| wakePulse | output | 1 | One-cycle remote wake request |

## Verification
Dominant pulses are driven at lengths just below, at, and just above the filter length, so that the strict "longer than" boundary is separated from an off-by-one error. Very short pulses and very long pulses are driven as well. An endless dominant level shows whether the detector waits for the recessive edge or fires on the timer alone. Disarming in the middle of a run shows that no state survives the disarm. The silent/sleep and transmit-data combinations separate the gating from the detection path. Random runs around the boundary, with random mode bits, are checked against an expected value the bench computes for each run. Each wake is also checked for its exact cycle and for its width.

// File: rtl/linWakePkg.sv
`timescale 1ns/1ps
package linWakePkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_TIMING = 2'd1,
    WK_QUAL   = 2'd2
  } wakeState_t;

  typedef struct packed {
    logic clearAll;
    logic loadOne;
    logic incr;
  } wakeStrobe_t;
endpackage

// File: rtl/linWakeDatapath.sv
`timescale 1ns/1ps
module linWakeDatapath
  import linWakePkg::*;
#(
  parameter int FILTER_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busDom,
  input  wakeStrobe_t strobe,
  output logic        fallSeen,
  output logic        riseSeen,
  output logic        domNow,
  output logic        limitHit
);
  localparam int CW = $clog2(FILTER_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILTER_CYCLES);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          syncA, syncB, prevDom;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevDom <= 1'b0;
    end else if (strobe.clearAll) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevDom <= 1'b0;
    end else begin
      syncA   <= busDom;
      syncB   <= syncA;
      prevDom <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.clearAll) begin
      runCnt <= '0;
    end else if (strobe.loadOne) begin
      runCnt <= ONE;
    end else if (strobe.incr && runCnt < LIMIT) begin
      runCnt <= runCnt + ONE;
    end
  end

  assign domNow   = syncB;
  assign fallSeen = syncB & ~prevDom;
  assign riseSeen = ~syncB & prevDom;
  assign limitHit = (runCnt == LIMIT);

  // R4: the run counter saturates and never passes the filter length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LIMIT);
endmodule

// File: rtl/linWakeControl.sv
`timescale 1ns/1ps
module linWakeControl
  import linWakePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arm,
  input  logic        silentSel,
  input  logic        txdLevel,
  input  logic        fallSeen,
  input  logic        riseSeen,
  input  logic        domNow,
  input  logic        limitHit,
  output wakeStrobe_t strobe,
  output logic        wakePulse
);
  wakeState_t stateQ, stateD;
  logic       armEff;
  logic       wakeD;

  assign armEff = arm & (~silentSel | txdLevel);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    wakeD  = 1'b0;
    if (!armEff) begin
      strobe.clearAll = 1'b1;
      stateD          = WK_IDLE;
    end else begin
      unique case (stateQ)
        WK_IDLE: begin
          if (fallSeen) begin
            strobe.loadOne = 1'b1;
            stateD         = WK_TIMING;
          end
        end
        WK_TIMING: begin
          if (riseSeen) begin
            stateD = WK_IDLE;
          end else if (domNow) begin
            strobe.incr = 1'b1;
            if (limitHit) stateD = WK_QUAL;
          end
        end
        WK_QUAL: begin
          if (riseSeen) begin
            wakeD  = 1'b1;
            stateD = WK_IDLE;
          end
        end
        default: stateD = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= WK_IDLE;
      wakePulse <= 1'b0;
    end else begin
      stateQ    <= stateD;
      wakePulse <= wakeD;
    end
  end

  // R1: a wake only follows a qualified dominant run
  assert_wake_from_qual_R1: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(stateQ) == WK_QUAL);
  // R2: a wake lasts a single cycle
  assert_wake_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
  // R3: qualification is reached only through the timing phase
  assert_qual_path_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == WK_QUAL && $past(stateQ) != WK_QUAL) |-> $past(stateQ) == WK_TIMING);
  // R7: disarm clears to idle with no wake
  assert_disarm_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> (stateQ == WK_IDLE && !wakePulse));
endmodule

// File: rtl/linWakeFilter.sv
`timescale 1ns/1ps
module linWakeFilter
  import linWakePkg::*;
#(
  parameter int FILTER_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic silentSel,
  input  logic txdLevel,
  input  logic busDom,
  output logic wakePulse
);
  wakeStrobe_t strobe;
  logic        fallSeen, riseSeen, domNow, limitHit;

  linWakeDatapath #(.FILTER_CYCLES(FILTER_CYCLES)) u_datapath (
    .clk(clk), .rstN(rstN), .busDom(busDom), .strobe(strobe),
    .fallSeen(fallSeen), .riseSeen(riseSeen), .domNow(domNow), .limitHit(limitHit)
  );

  linWakeControl u_control (
    .clk(clk), .rstN(rstN), .arm(arm), .silentSel(silentSel), .txdLevel(txdLevel),
    .fallSeen(fallSeen), .riseSeen(riseSeen), .domNow(domNow), .limitHit(limitHit),
    .strobe(strobe), .wakePulse(wakePulse)
  );
endmodule

// File: tb/linWakeFilter_bench.sv
`timescale 1ns/1ps
module linWakeFilter_bench;
  localparam int F = 40;

  logic clk = 1'b0;
  logic rstN, arm, silentSel, txdLevel, busDom;
  logic wakePulse;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  linWakeFilter #(.FILTER_CYCLES(F)) u_linWakeFilter (
    .clk(clk), .rstN(rstN), .arm(arm), .silentSel(silentSel),
    .txdLevel(txdLevel), .busDom(busDom), .wakePulse(wakePulse)
  );

  function automatic bit expectWake(int len, bit sil, bit txd);
    return (len > F) && (!sil || txd);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(int cycles, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (wakePulse) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  task automatic runPulse(int len, bit exp, string req);
    int cnt, first;
    busDom = 1'b1;
    repeat (len) @(negedge clk);
    busDom = 1'b0;
    observe(8, cnt, first);
    check(cnt == (exp ? 1 : 0), req, cnt, exp ? 1 : 0);
    if (exp) check(first == 3, {req, " latency R9"}, first, 3);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cnt, first;
    rstN = 1'b0; arm = 1'b0; silentSel = 1'b0; txdLevel = 1'b0; busDom = 1'b0;
    repeat (4) @(negedge clk);
    check(wakePulse == 1'b0, "R8 in reset", wakePulse, 0);
    rstN = 1'b1;
    observe(3, cnt, first);
    check(cnt == 0, "R8 after reset", cnt, 0);
    arm = 1'b1;
    repeat (3) @(negedge clk);

    runPulse(F + 1, 1, "R1 just over");
    runPulse(F, 0, "R3 equal length");
    runPulse(F - 1, 0, "R3 one short");
    runPulse(1, 0, "R3 glitch");
    runPulse(3 * F, 1, "R1 long run");
    runPulse(F + 1, 1, "R2 width");
    txdLevel = 1'b1;
    runPulse(F + 2, 1, "R6 sleep txd high");
    txdLevel = 1'b0;
    runPulse(F + 2, 1, "R6 sleep txd low");

    silentSel = 1'b1; txdLevel = 1'b0;
    runPulse(2 * F, 0, "R5 silent txd low");
    txdLevel = 1'b1;
    repeat (2) @(negedge clk);
    runPulse(2 * F, 1, "R5 silent txd high");
    silentSel = 1'b0; txdLevel = 1'b0;

    // R4 endless dominant
    busDom = 1'b1;
    observe(20 * F, cnt, first);
    check(cnt == 0, "R4 held dominant", cnt, 0);
    busDom = 1'b0;
    observe(8, cnt, first);
    check(cnt == 1 && first == 3, "R4 release", cnt * 10 + first, 13);
    repeat (4) @(negedge clk);

    // R7 disarm during a qualified run
    busDom = 1'b1;
    repeat (2 * F) @(negedge clk);
    arm = 1'b0;
    repeat (2) @(negedge clk);
    busDom = 1'b0;
    observe(8, cnt, first);
    check(cnt == 0, "R7 release while disarmed", cnt, 0);
    arm = 1'b1;
    repeat (3) @(negedge clk);
    // R7 a one-cycle disarm mid-run restarts timing
    busDom = 1'b1;
    repeat (F - 5) @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    arm = 1'b1;
    repeat (F - 10) @(negedge clk);
    busDom = 1'b0;
    observe(8, cnt, first);
    check(cnt == 0, "R7 restart after short disarm", cnt, 0);
    repeat (4) @(negedge clk);

    // random runs around the boundary
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      int len;
      bit sil, txd;
      len = F - 4 + int'($urandom % 9);
      if ($urandom % 5 == 0) len = 1 + int'($urandom % (3 * F));
      sil = 1'($urandom);
      txd = 1'($urandom);
      silentSel = sil; txdLevel = txd;
      repeat (2) @(negedge clk);
      runPulse(len, expectWake(len, sil, txd), "R1 R5 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule